// File: doc/BRIEF.md
# Coprocessor-0 Exception and Interrupt Controller

This block keeps the privileged exception state of a 64-bit core: a status word with interrupt enable, exception level, error level, interrupt mask and boot-vector select; a cause word with the delay-slot flag, the live interrupt-pending field and the exception code; a saved return address for ordinary exceptions; and a saved return address for error-level handling. When the pipeline reports an exception, the block records the state and issues a one-cycle program-counter redirect to the handler vector. When the pipeline reports an exception return, it redirects to the matching saved address and pulses a strobe that clears the load-linked reservation.

Interrupt requests arrive as eight level lines plus a timer line merged onto line 7. The block raises `irq_pending` whenever an enabled, unmasked request is present and the core is not already inside a handler. The pipeline then reports an exception with code 0 to take it. A global disable input hides all pending interrupts and drops interrupt-code exception requests. A plain register port reads and writes the four state registers. Every pin is a plain control or status pin: no interface here carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `cp0_exc_unit`

## Requirements
- R1: While reset is held, the status word reads 0x0040_0000 (only the boot-vector bit 22 set) and the cause word reads 0. `redirect_valid` is 1 with `redirect_pc` = 0xFFFF_FFFF_BFC0_0000, and `irq_pending` is 0.
- R2: `irq_pending` is 1 exactly when status bit 0 (IE) is 1, bits 1 (EXL) and 2 (ERL) are 0, and cause bits 15:8 ANDed with status bits 15:8 are nonzero.
- R3: While `irq_disable` is 1, `irq_pending` is 0, and an exception request with code 0 is dropped. It causes no redirect and changes no register.
- R4: An accepted exception taken with EXL clear stores `cur_pc` in the return register. It sets cause bit 31 to `exc_bd`, writes `exc_code` into cause bits 6:2, and keeps the interrupt-pending field.
- R5: An accepted exception taken with EXL already set leaves the return register unchanged, clears cause bit 31 and writes the new code into bits 6:2.
- R6: Every accepted exception sets EXL, so `irq_pending` is 0 in the following cycle.
- R7: The cycle after an accepted exception, `redirect_valid` is 1 and `redirect_pc` is 0xFFFF_FFFF_BFC0_0380 when status bit 22 is set, or 0xFFFF_FFFF_8000_0180 when it is clear.
- R8: An exception return with ERL set clears ERL and redirects to the error return register. Otherwise it clears EXL and redirects to the return register. In both cases `ll_clear` pulses together with the redirect.
- R9: Cause bits 15:8 follow `irq_lines` with one cycle of delay. Bit 15 is also set while `timer_irq` is 1. A register write cannot change these bits.
- R10: The register port selects with `csr_sel`: 0 status, 1 cause, 2 return register, 3 error return register. Status writes keep only bits 0, 1, 2, 15:8 and 22. Cause writes keep only bits 31 and 6:2.
- R11: An exception request outranks an exception return in the same cycle. A register write issued in the same cycle as an accepted exception or return is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request from the pipeline |
| exc_code | input | 5 | Exception code (0 interrupt, 8 syscall, 9 breakpoint, 13 trap) |
| exc_bd | input | 1 | Faulting instruction is in a branch delay slot |
| eret | input | 1 | Exception-return strobe |
| irq_lines | input | 8 | Live interrupt request lines |
| timer_irq | input | 1 | Timer request, merged onto line 7 |
| irq_disable | input | 1 | Global interrupt disable |
| cur_pc | input | 64 | Address of the faulting instruction |
| csr_wr | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Register read data (combinational from `csr_sel`) |
| redirect_pc | output | 64 | Next fetch address |
| redirect_valid | output | 1 | `redirect_pc` is to be taken this cycle |
| irq_pending | output | 1 | An enabled interrupt is waiting |
| ll_clear | output | 1 | Clear the load-linked reservation |

## Verification
The hardest situations to reach are a nested exception, where EXL is already set and the return address must survive, and an error-level return, which needs ERL set. Normal exception flow never sets ERL. The stimulus writes ERL and the error return address through the register port. It then takes an exception from that state and issues two returns in a row, so both return paths are used. Same-cycle collisions of an exception request, a return and a register write are driven on one edge, and the test checks which of them took effect.

// File: rtl/cp0_exc_pkg.sv
package cp0_exc_pkg;
  localparam int NIRQ     = 8;
  localparam int ST_IE    = 0;
  localparam int ST_EXL   = 1;
  localparam int ST_ERL   = 2;
  localparam int ST_BEV   = 22;
  localparam int F_LO     = 8;   // mask / pending field low bit
  localparam int CA_BD    = 31;
  localparam int CODE_LO  = 2;
  localparam int CODE_W   = 5;
  localparam logic [31:0] ST_WMASK = 32'h0040_FF07;
  localparam logic [31:0] CA_WMASK = 32'h8000_007C;
  localparam logic [4:0]  CODE_INT = 5'd0;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_RET    = 2'd2,
    SEL_ERRRET = 2'd3
  } csr_sel_e;
endpackage

// File: rtl/cp0_status_reg.sv
module cp0_status_reg
  import cp0_exc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exc_go,
  input  logic        eret_go,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] status
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= 32'h0;
      status[ST_BEV] <= 1'b1;
    end else if (exc_go) begin
      status[ST_EXL] <= 1'b1;
    end else if (eret_go) begin
      if (status[ST_ERL]) status[ST_ERL] <= 1'b0;
      else                status[ST_EXL] <= 1'b0;
    end else if (wr_en) begin
      status <= wr_data & ST_WMASK;
    end
  end

  assert_exl_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_go |=> status[ST_EXL]);
  assert_erl_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_go && status[ST_ERL]) |=> (!status[ST_ERL] && status[ST_EXL] == $past(status[ST_EXL])));
endmodule

// File: rtl/cp0_cause_reg.sv
module cp0_cause_reg
  import cp0_exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_go,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              exc_bd,
  input  logic              exl_now,
  input  logic [NIRQ-1:0]   lines_eff,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       cause
);
  logic              bd_q;
  logic [CODE_W-1:0] code_q;
  logic [NIRQ-1:0]   ip_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bd_q   <= 1'b0;
      code_q <= '0;
      ip_q   <= '0;
    end else begin
      ip_q <= lines_eff;
      if (exc_go) begin
        bd_q   <= exl_now ? 1'b0 : exc_bd;
        code_q <= exc_code;
      end else if (wr_en) begin
        bd_q   <= wr_data[CA_BD];
        code_q <= wr_data[CODE_LO +: CODE_W];
      end
    end
  end

  always_comb begin
    cause = 32'h0;
    cause[CA_BD] = bd_q;
    cause[F_LO +: NIRQ] = ip_q;
    cause[CODE_LO +: CODE_W] = code_q;
  end

  assert_ip_track_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cause[F_LO +: NIRQ] == $past(lines_eff));
  assert_bd_nested_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_go && exl_now) |=> !cause[CA_BD]);
endmodule

// File: rtl/cp0_ret_regs.sv
module cp0_ret_regs #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_go,
  input  logic            exl_now,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            wr_ret,
  input  logic            wr_err,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] ret_pc,
  output logic [XLEN-1:0] err_pc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_pc <= '0;
      err_pc <= '0;
    end else begin
      if (exc_go && !exl_now) ret_pc <= cur_pc;
      else if (wr_ret)        ret_pc <= wr_data;
      if (wr_err)             err_pc <= wr_data;
    end
  end

  assert_ret_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_go && !exl_now) |=> ret_pc == $past(cur_pc));
  assert_ret_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_go && exl_now) |=> $stable(ret_pc));
endmodule

// File: rtl/cp0_irq_eval.sv
module cp0_irq_eval
  import cp0_exc_pkg::*;
(
  input  logic [31:0] status,
  input  logic [31:0] cause,
  input  logic        irq_disable,
  output logic        pending
);
  logic [NIRQ-1:0] hit;
  for (genvar i = 0; i < NIRQ; i++) begin : g_line
    assign hit[i] = cause[F_LO + i] & status[F_LO + i];
  end
  assign pending = (|hit) && status[ST_IE] && !status[ST_EXL] &&
                   !status[ST_ERL] && !irq_disable;
endmodule

// File: rtl/cp0_redirect.sv
module cp0_redirect #(
  parameter int          XLEN      = 64,
  parameter logic [63:0] BOOT_PC   = 64'hFFFF_FFFF_BFC0_0000,
  parameter logic [63:0] BEV_BASE  = 64'hFFFF_FFFF_BFC0_0200,
  parameter logic [63:0] NORM_BASE = 64'hFFFF_FFFF_8000_0000,
  parameter logic [63:0] VEC_OFS   = 64'h180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_go,
  input  logic            eret_go,
  input  logic            bev,
  input  logic            erl,
  input  logic [XLEN-1:0] ret_pc,
  input  logic [XLEN-1:0] err_pc,
  output logic [XLEN-1:0] redirect_pc,
  output logic            redirect_valid,
  output logic            ll_clear
);
  localparam logic [XLEN-1:0] V_BEV  = XLEN'(BEV_BASE + VEC_OFS);
  localparam logic [XLEN-1:0] V_NORM = XLEN'(NORM_BASE + VEC_OFS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_pc    <= XLEN'(BOOT_PC);
      redirect_valid <= 1'b1;
      ll_clear       <= 1'b0;
    end else begin
      redirect_valid <= exc_go || eret_go;
      ll_clear       <= eret_go;
      if (exc_go)       redirect_pc <= bev ? V_BEV : V_NORM;
      else if (eret_go) redirect_pc <= erl ? err_pc : ret_pc;
    end
  end

  assert_vec_bev_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_go && bev) |=> (redirect_valid && redirect_pc == V_BEV));
  assert_llclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eret_go |=> (ll_clear && redirect_valid));
endmodule

// File: rtl/cp0_exc_unit.sv
module cp0_exc_unit
  import cp0_exc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_req,
  input  logic [4:0]      exc_code,
  input  logic            exc_bd,
  input  logic            eret,
  input  logic [7:0]      irq_lines,
  input  logic            timer_irq,
  input  logic            irq_disable,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            csr_wr,
  input  logic [1:0]      csr_sel,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic [XLEN-1:0] redirect_pc,
  output logic            redirect_valid,
  output logic            irq_pending,
  output logic            ll_clear
);
  logic [31:0]      status, cause;
  logic [XLEN-1:0]  ret_pc, err_pc;
  logic             exc_go, eret_go, wr_go;
  logic [NIRQ-1:0]  lines_eff;
  csr_sel_e         sel;

  assign sel       = csr_sel_e'(csr_sel);
  assign exc_go    = exc_req && !(exc_code == CODE_INT && irq_disable);
  assign eret_go   = eret && !exc_go;
  assign wr_go     = csr_wr && !exc_go && !eret_go;
  assign lines_eff = irq_lines | {timer_irq, {(NIRQ-1){1'b0}}};

  cp0_status_reg u_status (
    .clk(clk), .rst_n(rst_n), .exc_go(exc_go), .eret_go(eret_go),
    .wr_en(wr_go && sel == SEL_STATUS), .wr_data(csr_wdata[31:0]),
    .status(status));

  cp0_cause_reg u_cause (
    .clk(clk), .rst_n(rst_n), .exc_go(exc_go), .exc_code(exc_code),
    .exc_bd(exc_bd), .exl_now(status[ST_EXL]), .lines_eff(lines_eff),
    .wr_en(wr_go && sel == SEL_CAUSE), .wr_data(csr_wdata[31:0]),
    .cause(cause));

  cp0_ret_regs #(.XLEN(XLEN)) u_ret (
    .clk(clk), .rst_n(rst_n), .exc_go(exc_go), .exl_now(status[ST_EXL]),
    .cur_pc(cur_pc), .wr_ret(wr_go && sel == SEL_RET),
    .wr_err(wr_go && sel == SEL_ERRRET), .wr_data(csr_wdata),
    .ret_pc(ret_pc), .err_pc(err_pc));

  cp0_irq_eval u_eval (
    .status(status), .cause(cause), .irq_disable(irq_disable),
    .pending(irq_pending));

  cp0_redirect #(.XLEN(XLEN)) u_redir (
    .clk(clk), .rst_n(rst_n), .exc_go(exc_go), .eret_go(eret_go),
    .bev(status[ST_BEV]), .erl(status[ST_ERL]), .ret_pc(ret_pc),
    .err_pc(err_pc), .redirect_pc(redirect_pc),
    .redirect_valid(redirect_valid), .ll_clear(ll_clear));

  always_comb begin
    unique case (sel)
      SEL_STATUS: csr_rdata = XLEN'(status);
      SEL_CAUSE:  csr_rdata = XLEN'(cause);
      SEL_RET:    csr_rdata = ret_pc;
      default:    csr_rdata = err_pc;
    endcase
  end

  assert_no_pend_after_exc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req && !irq_disable |=> !irq_pending);
  assert_drop_int_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && exc_code == CODE_INT && irq_disable && !eret) |=> (!redirect_valid && $stable(status)));
  assert_exc_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !irq_disable && eret) |=> !ll_clear);
endmodule

// File: tb/test_cp0_exc_unit.sv
`timescale 1ns/1ps
module test_cp0_exc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 0, exc_bd = 0, eret = 0, timer_irq = 0, irq_disable = 0, csr_wr = 0;
  logic [4:0]  exc_code = 0;
  logic [7:0]  irq_lines = 0;
  logic [63:0] cur_pc = 0, csr_wdata = 0;
  logic [1:0]  csr_sel = 0;
  logic [63:0] csr_rdata, redirect_pc;
  logic        redirect_valid, irq_pending, ll_clear;

  localparam logic [63:0] BOOT  = 64'hFFFF_FFFF_BFC0_0000;
  localparam logic [63:0] V_BEV = 64'hFFFF_FFFF_BFC0_0380;
  localparam logic [63:0] V_NRM = 64'hFFFF_FFFF_8000_0180;

  cp0_exc_unit i_cp0_exc_unit (.*);

  always #2.5 clk = ~clk;

  typedef struct { logic [63:0] pc; logic ll; } exp_t;
  exp_t q[$];
  int   n_cmp = 0, n_bad = 0;
  bit   mon_en = 0, done = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [63:0] v);
    csr_sel = s; #0.5; v = csr_rdata;
  endtask

  task automatic wr(input logic [1:0] s, input logic [63:0] d);
    @(negedge clk); csr_sel = s; csr_wdata = d; csr_wr = 1;
    @(negedge clk); csr_wr = 0;
  endtask

  task automatic take(input logic [4:0] c, input logic bd, input logic [63:0] pc,
                      input bit expect_redir, input logic [63:0] vec);
    @(negedge clk); exc_req = 1; exc_code = c; exc_bd = bd; cur_pc = pc;
    if (expect_redir) q.push_back('{vec, 1'b0});
    @(negedge clk); exc_req = 0;
  endtask

  task automatic do_eret(input logic [63:0] dst);
    @(negedge clk); eret = 1; q.push_back('{dst, 1'b1});
    @(negedge clk); eret = 0;
  endtask

  // monitor: pops one expected redirect per observed redirect
  always @(negedge clk) begin
    if (mon_en) begin
      if (redirect_valid) begin
        if (q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R7/R8 unexpected redirect actual=%h expected=none", redirect_pc);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R7/R8 redirect_pc", redirect_pc, e.pc);
          chk("R8 ll_clear", {63'b0, ll_clear}, {63'b0, e.ll});
        end
      end else if (ll_clear) begin
        n_cmp++; n_bad++;
        $display("FAIL R8 stray ll_clear actual=1 expected=0");
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    // R1 reset state
    repeat (3) @(negedge clk);
    rd(0, v); chk("R1 status", v, 64'h0040_0000);
    rd(1, v); chk("R1 cause", v, 64'h0);
    chk("R1 redirect_valid", {63'b0, redirect_valid}, 64'h1);
    chk("R1 redirect_pc", redirect_pc, BOOT);
    chk("R1 irq_pending", {63'b0, irq_pending}, 64'h0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); mon_en = 1;

    // R2 / R10: enable IE with mask 0x81
    wr(0, 64'hFFFF_FFFF_0040_8101);
    rd(0, v); chk("R10 status mask", v, 64'h0040_8101);
    @(negedge clk); irq_lines = 8'h01;
    @(negedge clk); chk("R2 pending line0", {63'b0, irq_pending}, 64'h1);
    irq_lines = 8'h02;
    @(negedge clk); chk("R2 masked line1", {63'b0, irq_pending}, 64'h0);
    irq_lines = 8'h00; timer_irq = 1;
    @(negedge clk); chk("R9 timer on line7", {63'b0, irq_pending}, 64'h1);
    rd(1, v); chk("R9 cause ip", v, 64'h0000_8000);

    // R3 global disable
    irq_disable = 1; #0.5;
    chk("R3 pending forced off", {63'b0, irq_pending}, 64'h0);
    take(5'd0, 1'b0, 64'h2222, 0, 64'h0);
    rd(0, v); chk("R3 status untouched", v, 64'h0040_8101);
    rd(2, v); chk("R3 ret untouched", v, 64'h0);
    irq_disable = 0; #0.5;
    chk("R2 pending back", {63'b0, irq_pending}, 64'h1);

    // R4 / R6 / R7: syscall in delay slot, EXL clear, BEV set
    take(5'd8, 1'b1, 64'h1234, 1, V_BEV);
    rd(2, v); chk("R4 ret pc", v, 64'h1234);
    rd(1, v); chk("R4 cause bd/ip/code", v, 64'h8000_8020);
    rd(0, v); chk("R6 exl set", v, 64'h0040_8103);
    chk("R6 pending cleared", {63'b0, irq_pending}, 64'h0);

    // R5 nested exception
    take(5'd9, 1'b1, 64'h5678, 1, V_BEV);
    rd(2, v); chk("R5 ret held", v, 64'h1234);
    rd(1, v); chk("R5 bd cleared", v, 64'h0000_8024);

    // R8 normal return
    do_eret(64'h1234);
    rd(0, v); chk("R8 exl cleared", v, 64'h0040_8101);
    chk("R2 pending after return", {63'b0, irq_pending}, 64'h1);

    // R8 error-level path, R7 non-boot vector
    wr(0, 64'h0000_8105);
    chk("R2 erl blocks pending", {63'b0, irq_pending}, 64'h0);
    wr(3, 64'hABCD0);
    take(5'd13, 1'b0, 64'h9999, 1, V_NRM);
    rd(2, v); chk("R4 ret trap", v, 64'h9999);
    rd(0, v); chk("R6 status erl+exl", v, 64'h0000_8107);
    do_eret(64'hABCD0);
    rd(0, v); chk("R8 erl cleared first", v, 64'h0000_8103);
    do_eret(64'h9999);
    rd(0, v); chk("R8 exl cleared", v, 64'h0000_8101);

    // R11 collision: exception + return + write in one cycle
    @(negedge clk);
    exc_req = 1; exc_code = 5'd9; exc_bd = 0; cur_pc = 64'h4444; eret = 1;
    csr_wr = 1; csr_sel = 0; csr_wdata = 64'h0;
    q.push_back('{V_NRM, 1'b0});
    @(negedge clk); exc_req = 0; eret = 0; csr_wr = 0;
    rd(0, v); chk("R11 write dropped, exl set", v, 64'h0000_8103);
    rd(2, v); chk("R11 exception taken", v, 64'h4444);
    do_eret(64'h4444);

    // R9 / R10 IP not writable
    timer_irq = 0;
    @(negedge clk);
    wr(1, 64'h8000_FF34);
    rd(1, v); chk("R9 ip not writable", v, 64'h8000_0034);

    repeat (3) @(negedge clk);
    chk("R7 queue drained", 64'(q.size()), 64'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule